// File: doc/BRIEF.md
# Transceiver Reset and CDR Mode Control Registers

This block is the management-side register file for a serial transceiver with up to 32 channels. A word-addressed write/read bus programs per-channel serial loopback enables, clock-data-recovery (CDR) lock-mode overrides (lock to incoming data, lock to reference clock), and a channel mask for software-driven resets. The bus can also read back each channel's locked-to-data indication. That indication is first brought into the management clock domain through a two-stage synchronizer.

After power-on or a management reset, a built-in sequencer raises all three reset classes. It then releases them in a fixed order: TX digital first, then RX analog, then RX digital. Each phase lasts a parameterised number of management clock cycles. RX digital reset for a channel stays asserted until that channel reports lock to data.

Setting any bit of either CDR override register switches the block into manual mode. In manual mode the sequencer still drives TX digital reset, but the RX resets come only from software. Software asserts a reset by writing 1 to its bit in the fine-control register, and the reset stays asserted until software writes 0 to that bit. Each fine-control reset reaches only the channels enabled in the mask register.

Top module: `xcvr_rst_ctl`

## Requirements
- R1: While and right after mgmt_rst, all three reset outputs are all ones. Loopback, both CDR override outputs and the fine-control bits are zero, and the channel mask at 0x045 is all ones.
- R2: TX digital reset is released exactly HOLD_CYC clock edges after mgmt_rst is released.
- R3: RX analog reset is released exactly 2*HOLD_CYC edges after mgmt_rst is released.
- R4: From 3*HOLD_CYC edges after mgmt_rst is released, RX digital reset of channel n equals the inverse of channel n's synchronized lock input. Before that point it is held high.
- R5: The fine-control word at 0x045-1 (0x044) uses bit 1 for TX digital, bit 2 for RX analog and bit 3 for RX digital. A written 1 asserts that reset and holds it until a 0 is written to the same bit. Bits 0 and 31:4 are not stored and read as zero.
- R6: A fine-control reset reaches channel n only when bit n of the mask register at 0x045 is 1.
- R7: When any bit of 0x064 or 0x065 is nonzero (manual mode), the RX analog and RX digital outputs come only from the masked fine-control bits. The sequencer's RX contributions return once both registers are zero again.
- R8: Bit n of 0x061 drives loopback for channel n. Bit n of 0x064 drives lock-to-data for channel n. Bit n of 0x065 drives lock-to-reference for channel n. All three registers read back as written.
- R9: Address 0x066 reads the lock inputs after a two-flop synchronizer, so a change appears two clock edges later. Writes to 0x066 have no effect.
- R10: Writes to unmapped addresses change no register, and reads of unmapped addresses return zero.
- R11: bus_rdata is loaded on the clock edge at which bus_rd is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mgmt_clk | input | 1 | Management clock |
| mgmt_rst | input | 1 | Management reset, active high, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| lock_data_i | input | NCH | Per-channel CDR locked-to-data indication (asynchronous) |
| tx_dig_rst_o | output | NCH | Per-channel TX digital reset |
| rx_ana_rst_o | output | NCH | Per-channel RX analog reset |
| rx_dig_rst_o | output | NCH | Per-channel RX digital reset |
| loopback_o | output | NCH | Per-channel serial loopback enable |
| cdr_lock_data_o | output | NCH | Per-channel request to lock the CDR to data |
| cdr_lock_ref_o | output | NCH | Per-channel request to lock the CDR to the reference clock |

## Verification
Register-driven outputs, including the manual-mode gating, change one clock edge after a write. Read data appears one edge after the read strobe. A lock input change reaches the status word and the RX digital reset two edges later. The sequencer releases TX, RX analog and RX digital at HOLD_CYC, 2*HOLD_CYC and 3*HOLD_CYC edges after reset release. The bench drives every input on a falling edge and samples on a later falling edge. For each such result it checks once on the last edge before the change is due and once on the edge where it is due, so an early or late result is caught.

// File: rtl/xrc_pkg.sv
package xrc_pkg;

  typedef enum logic [1:0] {
    SQ_TX  = 2'd0,
    SQ_RXA = 2'd1,
    SQ_RXD = 2'd2,
    SQ_RUN = 2'd3
  } seq_st_t;

  // word addresses
  localparam int AD_FINE = 'h44;
  localparam int AD_MASK = 'h45;
  localparam int AD_LOOP = 'h61;
  localparam int AD_LTD  = 'h64;
  localparam int AD_LTR  = 'h65;
  localparam int AD_LOCK = 'h66;

  // fine-control bit positions
  localparam int FB_TX  = 1;
  localparam int FB_RXA = 2;
  localparam int FB_RXD = 3;

  function automatic seq_st_t seq_next(seq_st_t s);
    case (s)
      SQ_TX:   return SQ_RXA;
      SQ_RXA:  return SQ_RXD;
      default: return SQ_RUN;
    endcase
  endfunction

  function automatic logic addr_mapped(int a);
    return (a == AD_FINE) || (a == AD_MASK) || (a == AD_LOOP) ||
           (a == AD_LTD)  || (a == AD_LTR)  || (a == AD_LOCK);
  endfunction

endpackage

// File: rtl/xrc_sync.sv
module xrc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1;
  logic [W-1:0] stg2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        stg1[i] <= 1'b0;
        stg2[i] <= 1'b0;
      end else begin
        stg1[i] <= d_i[i];
        stg2[i] <= stg1[i];
      end
    end
  end

  assign q_o = stg2;

  // R9: a rising synchronized bit was high at the input two edges earlier
  a_r9_sync_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(stg2[0]) |-> $past(d_i[0], 2));
endmodule

// File: rtl/xrc_seq.sv
module xrc_seq
  import xrc_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic    clk,
  input  logic    rst,
  output seq_st_t state_o,
  output logic    auto_tx_o,
  output logic    auto_rxa_o,
  output logic    run_o
);
  localparam int CNT_W = $clog2(HOLD_CYC) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  seq_st_t          state;
  logic [CNT_W-1:0] cnt;
  logic             phase_end;

  assign phase_end = (cnt == LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= SQ_TX;
      cnt   <= '0;
    end else if (state != SQ_RUN) begin
      if (phase_end) begin
        state <= seq_next(state);
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign state_o    = state;
  assign auto_tx_o  = (state == SQ_TX);
  assign auto_rxa_o = (state == SQ_TX) || (state == SQ_RXA);
  assign run_o      = (state == SQ_RUN);

  // R4: phases only advance TX -> RXA -> RXD -> RUN
  a_r4_seq_order: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> (state == seq_next($past(state))));

  // R2: a phase only ends after its full hold count
  a_r2_hold_len: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/xrc_csr.sv
module xrc_csr
  import xrc_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    lock_sync,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        fine_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    loop_o,
  output logic [NCH-1:0]    ltd_o,
  output logic [NCH-1:0]    ltr_o
);
  logic [2:0]        fine_q;
  logic [NCH-1:0]    mask_q, loop_q, ltd_q, ltr_q;
  logic [DATA_W-1:0] rd_word;
  logic              fine_wr;
  logic              rd_unmapped;

  function automatic logic [DATA_W-1:0] widen(logic [NCH-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NCH-1:0] = v;
    return r;
  endfunction

  assign fine_wr     = wr_en && (int'(addr) == AD_FINE);
  assign rd_unmapped = rd_en && !addr_mapped(int'(addr));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      fine_q <= '0;
      mask_q <= '1;
      loop_q <= '0;
      ltd_q  <= '0;
      ltr_q  <= '0;
    end else if (wr_en) begin
      case (int'(addr))
        AD_FINE: fine_q <= wdata[FB_RXD:FB_TX];
        AD_MASK: mask_q <= wdata[NCH-1:0];
        AD_LOOP: loop_q <= wdata[NCH-1:0];
        AD_LTD:  ltd_q  <= wdata[NCH-1:0];
        AD_LTR:  ltr_q  <= wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (int'(addr))
      AD_FINE: rd_word[FB_RXD:FB_TX] = fine_q;
      AD_MASK: rd_word = widen(mask_q);
      AD_LOOP: rd_word = widen(loop_q);
      AD_LTD:  rd_word = widen(ltd_q);
      AD_LTR:  rd_word = widen(ltr_q);
      AD_LOCK: rd_word = widen(lock_sync);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  assign fine_o = fine_q;
  assign mask_o = mask_q;
  assign loop_o = loop_q;
  assign ltd_o  = ltd_q;
  assign ltr_o  = ltr_q;

  // R5: fine-control bits only change on a write to their address
  a_r5_fine_sticky: assert property (@(posedge clk) disable iff (rst)
    !fine_wr |=> $stable(fine_q));

  // R10: reading an unmapped address yields zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    rd_unmapped |=> (rdata == '0));

  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/xcvr_rst_ctl.sv
module xcvr_rst_ctl
  import xrc_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int HOLD_CYC = 8
) (
  input  logic              mgmt_clk,
  input  logic              mgmt_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    lock_data_i,
  output logic [NCH-1:0]    tx_dig_rst_o,
  output logic [NCH-1:0]    rx_ana_rst_o,
  output logic [NCH-1:0]    rx_dig_rst_o,
  output logic [NCH-1:0]    loopback_o,
  output logic [NCH-1:0]    cdr_lock_data_o,
  output logic [NCH-1:0]    cdr_lock_ref_o
);
  logic [NCH-1:0] lock_sync;
  logic [2:0]     fine;
  logic [NCH-1:0] mask, ltd, ltr;
  seq_st_t        seq_state;
  logic           auto_tx, auto_rxa, seq_run;
  logic           manual;
  logic [NCH-1:0] auto_rxd;

  xrc_sync #(.W(NCH)) u_sync (
    .clk(mgmt_clk), .rst(mgmt_rst), .d_i(lock_data_i), .q_o(lock_sync)
  );

  xrc_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(mgmt_clk), .rst(mgmt_rst), .state_o(seq_state),
    .auto_tx_o(auto_tx), .auto_rxa_o(auto_rxa), .run_o(seq_run)
  );

  xrc_csr #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_csr (
    .clk(mgmt_clk), .rst(mgmt_rst), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .lock_sync(lock_sync),
    .rdata(bus_rdata), .fine_o(fine), .mask_o(mask), .loop_o(loopback_o),
    .ltd_o(ltd), .ltr_o(ltr)
  );

  assign manual = (|ltd) || (|ltr);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign auto_rxd[i] = !seq_run || !lock_sync[i];
  end

  assign tx_dig_rst_o = {NCH{auto_tx}} | ({NCH{fine[0]}} & mask);
  assign rx_ana_rst_o = (manual ? '0 : {NCH{auto_rxa}}) | ({NCH{fine[1]}} & mask);
  assign rx_dig_rst_o = (manual ? '0 : auto_rxd) | ({NCH{fine[2]}} & mask);

  assign cdr_lock_data_o = ltd;
  assign cdr_lock_ref_o  = ltr;

  // R6: outside the TX phase, masked-off channels never see TX reset
  a_r6_mask_gate: assert property (@(posedge mgmt_clk) disable iff (mgmt_rst)
    !auto_tx |-> ((tx_dig_rst_o & ~mask) == '0));

  // R7: in manual mode RX analog reset follows only the software bit
  a_r7_manual_rx: assert property (@(posedge mgmt_clk) disable iff (mgmt_rst)
    (manual && !fine[1]) |-> (rx_ana_rst_o == '0));

  // R3: RX analog auto reset is never released before TX
  a_r3_order: assert property (@(posedge mgmt_clk) disable iff (mgmt_rst)
    (seq_state == SQ_TX) |-> auto_rxa);
endmodule

// File: tb/xcvr_rst_ctl_test.sv
`timescale 1ns/1ps
module xcvr_rst_ctl_test;
  localparam int NCH = 32;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int H   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] lock = '0;
  logic [NCH-1:0] txr, rxa, rxd, lpb, ltd, ltr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  xcvr_rst_ctl #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW), .HOLD_CYC(H)) uut (
    .mgmt_clk(clk), .mgmt_rst(rst), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .lock_data_i(lock), .tx_dig_rst_o(txr), .rx_ana_rst_o(rxa),
    .rx_dig_rst_o(rxd), .loopback_o(lpb), .cdr_lock_data_o(ltd),
    .cdr_lock_ref_o(ltr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd = 1'b0; addr = '0;
    d = rdata;
  endtask

  task automatic t_reset_seq();
    logic [31:0] v;
    lock = 32'h0000_00FF;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 tx", txr, '1);
    chk("R1 rxa", rxa, '1);
    chk("R1 rxd", rxd, '1);
    chk("R1 loop", lpb, '0);
    chk("R1 ltd", ltd, '0);
    chk("R1 ltr", ltr, '0);
    repeat (H - 1) @(negedge clk);
    chk("R2 tx held", txr, '1);
    @(negedge clk);
    chk("R2 tx released", txr, '0);
    chk("R3 rxa held", rxa, '1);
    repeat (H - 1) @(negedge clk);
    chk("R3 rxa held late", rxa, '1);
    @(negedge clk);
    chk("R3 rxa released", rxa, '0);
    repeat (H - 1) @(negedge clk);
    chk("R4 rxd held", rxd, '1);
    @(negedge clk);
    chk("R4 rxd per lock", rxd, 32'hFFFF_FF00);
    rd_reg('h45, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd_reg('h44, v); chk("R1 fine", v, 32'h0);
  endtask

  task automatic t_lock_sync();
    logic [31:0] v;
    @(negedge clk);
    lock = '1;
    @(negedge clk);
    chk("R9 rxd one edge", rxd, 32'hFFFF_FF00);
    @(negedge clk);
    chk("R4 rxd after sync", rxd, 32'h0);
    rd_reg('h66, v); chk("R9 status", v, 32'hFFFF_FFFF);
    wr_reg('h66, 32'h0);
    rd_reg('h66, v); chk("R9 write ignored", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_fine();
    logic [31:0] v;
    wr_reg('h45, 32'h0000_00F0);
    wr_reg('h44, 32'h0000_0002);
    chk("R6 tx masked", txr, 32'h0000_00F0);
    chk("R5 rxa untouched", rxa, 32'h0);
    wr_reg('h44, 32'hFFFF_FFF1);
    chk("R5 tx cleared", txr, 32'h0);
    rd_reg('h44, v); chk("R5 reserved zero", v, 32'h0);
    wr_reg('h44, 32'h0000_000E);
    chk("R5 tx", txr, 32'h0000_00F0);
    chk("R5 rxa", rxa, 32'h0000_00F0);
    chk("R5 rxd", rxd, 32'h0000_00F0);
    rd_reg('h44, v); chk("R5 readback", v, 32'h0000_000E);
    wr_reg('h61, 32'h0);
    repeat (3) @(negedge clk);
    chk("R5 sticky", rxa, 32'h0000_00F0);
    wr_reg('h44, 32'h0);
    chk("R5 release", txr | rxa | rxd, 32'h0);
    wr_reg('h45, 32'hFFFF_FFFF);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr_reg('h61, 32'hA5A5_0001);
    chk("R8 loop out", lpb, 32'hA5A5_0001);
    rd_reg('h61, v); chk("R8 loop rd", v, 32'hA5A5_0001);
    wr_reg('h64, 32'h0000_0010);
    chk("R8 ltd out", ltd, 32'h0000_0010);
    wr_reg('h65, 32'h8000_0000);
    chk("R8 ltr out", ltr, 32'h8000_0000);
    rd_reg('h65, v); chk("R8 ltr rd", v, 32'h8000_0000);
    wr_reg('h64, 32'h0);
    wr_reg('h65, 32'h0);
    wr_reg('h61, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd_reg('h45, v);
    wr_reg('h50, 32'hFFFF_FFFF);
    wr_reg('h46, 32'hFFFF_FFFF);
    chk("R11 rdata holds", rdata, 32'hFFFF_FFFF);
    chk("R10 no side effect", txr | rxa | rxd | lpb | ltd | ltr, 32'h0);
    rd_reg('h50, v); chk("R10 read zero", v, 32'h0);
    rd_reg('h44, v); chk("R10 fine intact", v, 32'h0);
    rd_reg('h45, v); chk("R10 mask intact", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_manual();
    @(negedge clk);
    lock = 32'h0000_FFFF;
    repeat (3) @(negedge clk);
    chk("R4 auto rxd", rxd, 32'hFFFF_0000);
    wr_reg('h64, 32'h0000_0001);
    chk("R7 manual rxd", rxd, 32'h0);
    wr_reg('h44, 32'h0000_0008);
    chk("R7 sw rxd", rxd, 32'hFFFF_FFFF);
    chk("R7 sw rxa off", rxa, 32'h0);
    wr_reg('h44, 32'h0);
    chk("R7 sw rxd off", rxd, 32'h0);
    wr_reg('h64, 32'h0);
    wr_reg('h65, 32'h0000_0002);
    chk("R7 ltr manual", rxd, 32'h0);
    wr_reg('h65, 32'h0);
    chk("R7 auto back", rxd, 32'hFFFF_0000);
  endtask

  initial begin
    t_reset_seq();
    t_lock_sync();
    t_fine();
    t_regs();
    t_unmapped();
    t_manual();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule